// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Responder

This block is the target side of a two-wire serial memory on a shared clock/data bus. It reads the bus clock and data lines as synchronous inputs on the system clock. It finds start and stop conditions and decodes the device byte that follows a start. When the device byte selects this memory for a read, the block acknowledges it. It then sends bytes from its internal array, most significant bit first. A word pointer moves forward after every byte, so one read can continue through as many consecutive addresses as the master wants.

The master can aim a read at any word with a short addressing phase. It sends the device byte with the direction bit cleared, then one word-address byte, then a repeated start and a read device byte. Without that phase, a read starts wherever the pointer was left. The pointer keeps its value across stop conditions. The block never drives the data line high: `sda_oe` high means "pull the line low". The array is filled from the side through a backdoor write port. The bus cannot write the array.

Top module: `serial_mem_reader`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` is 0 and `word_ptr` is 0.
- R2: The device byte is sent MSB first. Bits [7:4] are the device identity 4'b1010, bits [3:1] are a block select and bit [0] is the direction (1 = read). For a read, the block acknowledges by driving `sda_oe` high through the ninth clock when the identity matches and the block select equals `word_ptr[10:8]`.
- R3: When the identity or, for a read, the block select does not match, SDA stays released through the ninth clock and through any later clocks until the next start. `word_ptr` is not changed.
- R4: After an acknowledged read device byte, the block sends the byte stored at `word_ptr`, D7 first. Each bit is presented while SCL is low and held through the high phase.
- R5: `word_ptr` advances by one on the falling SCL edge of the eighth data bit of each byte it sends, and at no other time except R8.
- R6: When the master acknowledges a data byte, the byte at the next word follows. When the master does not acknowledge, SDA stays released and the block goes idle, and the master then stops the bus.
- R7: Advancing from word 2047 gives word 0.
- R8: A write device byte whose identity matches is acknowledged. The next byte is acknowledged too, and `word_ptr` becomes {block select, that byte}. A repeated start with a read device byte then reads from that word.
- R9: A start condition at any point restarts device-byte reception. A stop condition at any point returns the block to idle. Both release SDA.
- R10: `word_ptr` keeps its value across stop conditions, so a later read with no addressing phase continues from the next unread word.
- R11: `sda_oe` changes only while SCL is low, except when a start or stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level, synchronous to clk |
| sda_i | input | 1 | Bus data level as seen on the wire, synchronous to clk |
| bd_we | input | 1 | Backdoor write strobe for the array |
| bd_addr | input | 11 | Backdoor write address |
| bd_data | input | 8 | Backdoor write data |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| word_ptr | output | 11 | Current word pointer |

## Verification
The assertions assume that SCL and SDA are already synchronous to `clk`. They also assume each level holds for at least two system clocks between changes. The master changes data only while SCL is low, except when it makes a deliberate start or stop. The bench meets this by driving both lines on falling clock edges, with four system clocks per quarter bus period. It makes starts and stops only while the data line is released by the block: when the bus is idle, after an acknowledge slot, or during its own address bits.

// File: rtl/serial_mem_reader.sv
module serial_mem_reader #(
  parameter int BLK_BITS = 3,
  parameter logic [6-BLK_BITS:0] DEV_ID = 4'b1010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  bd_we,
  input  logic [7+BLK_BITS:0]   bd_addr,
  input  logic [7:0]            bd_data,
  output logic                  sda_oe,
  output logic [7+BLK_BITS:0]   word_ptr
);
  localparam int AW = 8 + BLK_BITS;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_DACK, S_WADR, S_WACK, S_TX, S_MACK} st_t;

  logic [7:0]          mem [DEPTH];
  st_t                 st;
  logic                scl_q, sda_q;
  logic [7:0]          sh;
  logic [2:0]          bcnt;
  logic                full, rd_q, mack;
  logic [AW-1:0]       ptr;
  logic [BLK_BITS-1:0] blk;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire rx       = (st == S_DEV) | (st == S_WADR);
  wire id_ok    = sh[7:BLK_BITS+1] == DEV_ID;
  wire blk_ok   = sh[BLK_BITS:1] == ptr[AW-1:8];

  assign sda_oe   = (st == S_DACK) | (st == S_WACK) | ((st == S_TX) & ~sh[7]);
  assign word_ptr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  always_ff @(posedge clk)
    if (bd_we) mem[bd_addr] <= bd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sh   <= '0;
      bcnt <= '0;
      full <= 1'b0;
      rd_q <= 1'b0;
      mack <= 1'b0;
      ptr  <= '0;
      blk  <= '0;
    end else if (start_c) begin
      st   <= S_DEV;
      bcnt <= '0;
      full <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else begin
      if (rx && scl_rise) begin
        sh   <= {sh[6:0], sda_i};
        bcnt <= bcnt + 3'd1;
        full <= (bcnt == 3'd7);
      end
      if (st == S_MACK && scl_rise) mack <= ~sda_i;
      if (scl_fall) begin
        case (st)
          S_DEV: if (full) begin
            full <= 1'b0;
            rd_q <= sh[0];
            if (id_ok && (!sh[0] || blk_ok)) st <= S_DACK;
            else st <= S_IDLE;
            if (id_ok && !sh[0]) blk <= sh[BLK_BITS:1];
          end
          S_DACK: begin
            bcnt <= '0;
            if (rd_q) begin
              st <= S_TX;
              sh <= mem[ptr];
            end else begin
              st <= S_WADR;
            end
          end
          S_WADR: if (full) begin
            full <= 1'b0;
            ptr  <= {blk, sh};
            st   <= S_WACK;
          end
          S_WACK: st <= S_IDLE;
          S_TX: if (bcnt == 3'd7) begin
            ptr <= ptr + ONE;
            st  <= S_MACK;
          end else begin
            sh   <= {sh[6:0], 1'b0};
            bcnt <= bcnt + 3'd1;
          end
          S_MACK: if (mack) begin
            st   <= S_TX;
            sh   <= mem[ptr];
            bcnt <= '0;
          end else begin
            st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_mem_reader_chk.sv
module serial_mem_reader_chk #(
  parameter int BLK_BITS = 3,
  parameter logic [6-BLK_BITS:0] DEV_ID = 4'b1010
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_i,
  input logic                sda_i,
  input logic                scl_q,
  input logic                sda_q,
  input logic                sda_oe,
  input logic [7+BLK_BITS:0] word_ptr,
  input logic                st_idle,
  input logic                st_dev,
  input logic                st_wadr,
  input logic                st_tx,
  input logic                st_mack,
  input logic                full,
  input logic                mack,
  input logic [6-BLK_BITS:0] id_rx
);
  localparam int AW = 8 + BLK_BITS;
  localparam logic [AW-1:0] ONE = 1;

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (word_ptr == '0 && !sda_oe));

  a_r11_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_i) || $past(scl_i && scl_q && (sda_i != sda_q))));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_ptr) |-> (($past(st_tx) && word_ptr == $past(word_ptr) + ONE) || $past(st_wadr)));

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q && sda_q && !sda_i) |=> (st_dev && !sda_oe));

  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q && !sda_q && sda_i) |=> (st_idle && !sda_oe));

  a_r3_foreign_id: assert property (@(posedge clk) disable iff (!rst_n)
    (st_dev && full && scl_q && !scl_i && id_rx != DEV_ID) |=> (st_idle && !sda_oe));

  a_r6_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mack && scl_q && !scl_i && !mack) |=> (st_idle && !sda_oe));
endmodule

bind serial_mem_reader serial_mem_reader_chk #(.BLK_BITS(BLK_BITS), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .scl_q(scl_q), .sda_q(sda_q),
  .sda_oe(sda_oe), .word_ptr(word_ptr),
  .st_idle(st == S_IDLE), .st_dev(st == S_DEV), .st_wadr(st == S_WADR),
  .st_tx(st == S_TX), .st_mack(st == S_MACK),
  .full(full), .mack(mack), .id_rx(sh[7:BLK_BITS+1])
);

// File: tb/serial_mem_reader_bench.sv
module serial_mem_reader_bench;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic bd_we = 1'b0;
  logic [10:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic sda_oe;
  logic [10:0] word_ptr;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  serial_mem_reader u_serial_mem_reader (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data),
    .sda_oe(sda_oe), .word_ptr(word_ptr)
  );

  int nchk = 0;
  int nbad = 0;
  string cur_tag = "R4";
  logic [7:0] expq[$];
  logic [7:0] got;
  event got_ev;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7) ^ 8'(a >> 3) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hc(Q); scl = 1'b1; hc(Q); sda_m = 1'b0; hc(Q); scl = 1'b0; hc(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; hc(Q); scl = 1'b1; hc(Q); sda_m = 1'b1; hc(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; hc(Q); scl = 1'b1; hc(Q); r = sda_bus; hc(Q); scl = 1'b0; hc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  // mode: 0 master nack, 1 master ack, 2 start in the ack slot
  task automatic recv_byte(input logic [10:0] a, input int mode, input string tag);
    logic [7:0] v;
    logic r;
    cur_tag = tag;
    expq.push_back(pat(int'(a)));
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hc(Q); scl = 1'b1; hc(Q);
      v[i] = sda_bus;
      if (i == 0) chk(word_ptr == a, "R5 pointer before 8th fall", int'(word_ptr), int'(a));
      hc(Q);
      chk(sda_bus == v[i], "R11 data held while SCL high", int'(sda_bus), int'(v[i]));
      scl = 1'b0; hc(Q);
    end
    chk(word_ptr == 11'(a + 11'd1), "R5 pointer after 8th fall", int'(word_ptr), int'(11'(a + 11'd1)));
    got = v;
    ->got_ev;
    if (mode == 2) begin
      sda_m = 1'b1; hc(Q); scl = 1'b1; hc(Q); sda_m = 1'b0; hc(Q); scl = 1'b0; hc(Q);
      chk(!sda_oe, "R9 start in ack slot releases", int'(sda_oe), 0);
    end else begin
      clk_bit(mode == 0, r);
    end
  endtask

  initial forever begin
    @(got_ev);
    if (expq.size() == 0) chk(1'b0, "R4 unexpected byte", int'(got), 0);
    else begin : pop
      logic [7:0] e;
      e = expq.pop_front();
      chk(got == e, cur_tag, int'(got), int'(e));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic ak;
    logic r;
    hc(3);
    chk(!sda_oe, "R1 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1; hc(2);
    chk(!sda_oe, "R1 oe after reset", int'(sda_oe), 0);
    chk(word_ptr == 0, "R1 pointer after reset", int'(word_ptr), 0);

    for (int a = 0; a < 2048; a++) begin
      bd_we = 1'b1; bd_addr = 11'(a); bd_data = pat(a); hc(1);
    end
    bd_we = 1'b0; hc(2);

    // current read from 0, sequential, then nack + stop
    bstart(); send_byte(8'hA1, ak);
    chk(ak, "R2 read device byte acknowledged", int'(ak), 1);
    recv_byte(11'd0, 1, "R4 first byte");
    recv_byte(11'd1, 1, "R6 acked continuation");
    recv_byte(11'd2, 1, "R6 acked continuation");
    recv_byte(11'd3, 0, "R6 last byte");
    bstop();
    chk(!sda_oe, "R6 released after nack and stop", int'(sda_oe), 0);
    chk(word_ptr == 11'd4, "R10 pointer kept over stop", int'(word_ptr), 4);

    // later current read continues
    bstart(); send_byte(8'hA1, ak);
    chk(ak, "R2 second read acknowledged", int'(ak), 1);
    recv_byte(11'd4, 1, "R10 continues after stop");
    recv_byte(11'd5, 0, "R10 continues after stop");
    bstop();

    // wrong identity
    bstart(); send_byte(8'hB1, ak);
    chk(!ak, "R3 wrong identity not acknowledged", int'(ak), 0);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r);
      chk(r == 1'b1, "R3 line stays released", int'(r), 1);
    end
    bstop();
    // wrong block select for a read
    bstart(); send_byte(8'hA7, ak);
    chk(!ak, "R3 wrong block not acknowledged", int'(ak), 0);
    bstop();
    chk(word_ptr == 11'd6, "R3 pointer untouched", int'(word_ptr), 6);

    // addressed read near the top, wrapping
    bstart(); send_byte(8'hAE, ak);
    chk(ak, "R8 write device byte acknowledged", int'(ak), 1);
    send_byte(8'hFE, ak);
    chk(ak, "R8 word byte acknowledged", int'(ak), 1);
    chk(word_ptr == 11'h7FE, "R8 pointer loaded", int'(word_ptr), 'h7FE);
    bstart(); send_byte(8'hAF, ak);
    chk(ak, "R8 read after repeated start acknowledged", int'(ak), 1);
    recv_byte(11'h7FE, 1, "R8 addressed byte");
    recv_byte(11'h7FF, 1, "R7 last word");
    recv_byte(11'h000, 1, "R7 wrapped to zero");
    recv_byte(11'h001, 0, "R7 after wrap");
    bstop();
    chk(word_ptr == 11'd2, "R7 pointer after wrap", int'(word_ptr), 2);

    // start in the master ack slot aborts the sequence
    bstart(); send_byte(8'hA1, ak);
    chk(ak, "R2 acknowledged before abort", int'(ak), 1);
    recv_byte(11'd2, 2, "R9 byte before abort");
    send_byte(8'hA1, ak);
    chk(ak, "R9 new device byte after start", int'(ak), 1);
    recv_byte(11'd3, 0, "R9 read after restart");
    bstop();

    // stop in the middle of a device byte
    bstart();
    for (int i = 7; i >= 4; i--) clk_bit(1'(8'hA1 >> i), r);
    bstop();
    chk(!sda_oe, "R9 stop mid address releases", int'(sda_oe), 0);
    bstart(); send_byte(8'hA1, ak);
    chk(ak, "R9 read after aborted address", int'(ak), 1);
    recv_byte(11'd4, 0, "R10 read after abort");
    bstop();
    chk(word_ptr == 11'd5, "R10 final pointer", int'(word_ptr), 5);
    chk(expq.size() == 0, "R4 all expected bytes seen", expq.size(), 0);

    hc(4);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule